// File: doc/BRIEF.md
# Power-Down Mode Controller

This block turns a 6-bit power-down request, written by the CPU into its control/status register, into clock-gating decisions for the chip. A write starts a fixed entry delay. After the delay the block settles in one of three low-power modes. The light mode gates only the CPU core clock and keeps interrupt logic and DMA running. The deep modes stop the PLL output clock, so the whole chip halts. The request code also selects the wake source, so the light mode exists in two forms. One wakes only on an enabled interrupt. The other wakes on any interrupt.

On leaving the light mode through an interrupt, the block raises a one-cycle pulse. The pulse tells the core either to run the interrupt service routine or to resume at the point where the mode took effect. The two deep modes can only be left through device reset. Leaving the deepest mode also waits out a modelled PLL relock period, and both clock enables stay off until that period ends. Every wake clears the request field, so entering a mode again takes a new write. A code outside the legal set leaves the chip running and sets a sticky error flag.

The FSM states are RUN, ENTRY, PD1, PD2, PD3, RSTHOLD and RELOCK. The transitions are:
- RUN→ENTRY on a write of a legal non-zero code.
- ENTRY→PD1, PD2 or PD3 when the entry timer expires.
- ENTRY→RUN on device reset.
- PD1→RUN on a wake interrupt or on device reset.
- PD2→RUN on device reset.
- PD3→RSTHOLD on device reset.
- RSTHOLD→RELOCK when device reset is released.
- RELOCK→RUN when the relock timer expires.
- RELOCK→RSTHOLD on device reset.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), the block is in RUN. Both clock enables are 1. `mode_active`, `pd_field`, `code_err`, `wake_isr` and `wake_resume` are all 0.
- R2: `csr_pd_wdata` carries register bits 15..10, with index 5 being bit 15. A write is taken only in RUN, and its value is read back on `pd_field`. A write in any other state leaves `pd_field` unchanged.
- R3: The codes decode as follows, and no other code requests a mode:
  - 6'b001001 selects PD1, woken by an enabled interrupt only.
  - 6'b010001 selects PD1, woken by any interrupt.
  - 6'b011010 selects PD2.
  - 6'b011100 selects PD3.
  - 6'b000000 selects no power-down.
- R4: After a legal mode write is sampled at clock edge k, both clock enables stay 1 and `mode_active` stays 0 up to edge k+8. The mode takes effect at edge k+9 (ENTRY_CYCLES = 9).
- R5: In PD1, `cpu_clk_en` is 0, `pll_clk_en` is 1 and `mode_active` is 1.
- R6: In PD1, an enabled interrupt (`irq_en_pend`) returns the block to RUN at the next edge. If `gie` and `nmie` are both 1, it pulses `wake_isr` for one cycle. Otherwise it pulses `wake_resume`. An enabled interrupt takes priority over a non-enabled one.
- R7: A non-enabled interrupt (`irq_ne_pend`) wakes PD1 with a `wake_resume` pulse only under code 010001. Under code 001001 it has no effect.
- R8: In PD2, both clock enables are 0 and interrupts have no effect. Device reset (`dev_rst_n` low) returns the block to RUN at the next edge, with both enables 1 and no relock wait.
- R9: In PD3, both clock enables are 0 and interrupts have no effect. After device reset is released, both enables stay 0 for RELOCK_CYCLES (64) cycles and then return to 1.
- R10: A write of any other code, for example 6'b100000 with the reserved bit set, requests no mode and sets `code_err`. `code_err` stays 1 until power-on reset.
- R11: Every wake, by interrupt or by device reset, clears `pd_field` to 6'b000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_n | input | 1 | Device reset, sampled synchronously, active low; the only wake source for PD2 and PD3 |
| csr_wr_en | input | 1 | Write strobe for the power-down field |
| csr_pd_wdata | input | 6 | Field value (register bits 15..10) |
| irq_en_pend | input | 1 | An enabled interrupt is pending |
| irq_ne_pend | input | 1 | A non-enabled interrupt is pending |
| gie | input | 1 | Global interrupt enable |
| nmie | input | 1 | Non-maskable interrupt enable |
| pd_field | output | 6 | Read-back of the stored field |
| mode_active | output | 1 | A low-power mode is in effect |
| cpu_clk_en | output | 1 | Clock enable at the CPU core boundary |
| pll_clk_en | output | 1 | Enable for the PLL output clock |
| wake_isr | output | 1 | One-cycle pulse: PD1 left, run the service routine |
| wake_resume | output | 1 | One-cycle pulse: PD1 left, resume execution |
| code_err | output | 1 | Sticky flag for a reserved code |

## Verification
The assertions check several properties on every cycle:
- An active mode always has the core clock gated, and a stopped PLL never leaves the core clock running.
- The two wake pulses never overlap.
- A service-routine pulse is always preceded by an enabled interrupt with both enables set.
- A wake always comes with a cleared field.
- The error flag never drops.
- The field cannot move while a mode holds.

Only the directed scenarios can show the exact nine-cycle entry point, the code-by-code choice of wake source, the length of the relock wait, and that a reserved code leaves the clocks running.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    localparam int PD_FIELD_W = 6;

    localparam logic [PD_FIELD_W-1:0] CODE_NONE   = 6'b000000;
    localparam logic [PD_FIELD_W-1:0] CODE_PD1_EN = 6'b001001;
    localparam logic [PD_FIELD_W-1:0] CODE_PD1_ANY = 6'b010001;
    localparam logic [PD_FIELD_W-1:0] CODE_PD2    = 6'b011010;
    localparam logic [PD_FIELD_W-1:0] CODE_PD3    = 6'b011100;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_ENTRY,
        ST_PD1,
        ST_PD2,
        ST_PD3,
        ST_RSTHOLD,
        ST_RELOCK
    } pd_state_e;

    typedef enum logic [2:0] {
        MD_NONE,
        MD_PD1_EN,
        MD_PD1_ANY,
        MD_PD2,
        MD_PD3,
        MD_BAD
    } pd_mode_e;

endpackage

// File: rtl/pd_decode.sv
module pd_decode
    import pwrdn_pkg::*;
(
    input  logic [PD_FIELD_W-1:0] code,
    output pd_mode_e              mode
);

    always_comb begin
        unique case (code)
            CODE_NONE:    mode = MD_NONE;
            CODE_PD1_EN:  mode = MD_PD1_EN;
            CODE_PD1_ANY: mode = MD_PD1_ANY;
            CODE_PD2:     mode = MD_PD2;
            CODE_PD3:     mode = MD_PD3;
            default:      mode = MD_BAD;
        endcase
    end

endmodule

// File: rtl/pd_timer.sv
module pd_timer #(
    parameter int LIMIT = 9
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic done
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            count <= '0;
        end else if (!run || done) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    assign done = run && (count == LAST);

endmodule

// File: rtl/pd_fsm.sv
module pd_fsm
    import pwrdn_pkg::*;
(
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  dev_rst_n,
    input  logic                  wr_en,
    input  logic [PD_FIELD_W-1:0] wr_field,
    input  pd_mode_e              wr_mode,
    input  pd_mode_e              held_mode,
    input  logic                  irq_en,
    input  logic                  irq_ne,
    input  logic                  gie,
    input  logic                  nmie,
    input  logic                  entry_done,
    input  logic                  relock_done,
    output logic [PD_FIELD_W-1:0] field,
    output logic                  err,
    output logic                  wake_isr,
    output logic                  wake_res,
    output logic                  entry_run,
    output logic                  relock_run,
    output logic                  mode_active,
    output logic                  cpu_en,
    output logic                  pll_en
);

    pd_state_e             st, nxt;
    logic [PD_FIELD_W-1:0] fld_n;
    logic                  err_n, isr_n, res_n;

    // next-state and register update values
    always_comb begin
        nxt   = st;
        fld_n = field;
        err_n = err;
        isr_n = 1'b0;
        res_n = 1'b0;
        unique case (st)
            ST_RUN: begin
                if (!dev_rst_n) begin
                    fld_n = CODE_NONE;
                end else if (wr_en) begin
                    fld_n = wr_field;
                    if (wr_mode == MD_BAD) begin
                        err_n = 1'b1;
                    end else if (wr_mode != MD_NONE) begin
                        nxt = ST_ENTRY;
                    end
                end
            end
            ST_ENTRY: begin
                if (!dev_rst_n) begin
                    nxt   = ST_RUN;
                    fld_n = CODE_NONE;
                end else if (entry_done) begin
                    if (held_mode == MD_PD2)      nxt = ST_PD2;
                    else if (held_mode == MD_PD3) nxt = ST_PD3;
                    else                          nxt = ST_PD1;
                end
            end
            ST_PD1: begin
                if (!dev_rst_n) begin
                    nxt   = ST_RUN;
                    fld_n = CODE_NONE;
                end else if (irq_en) begin
                    nxt   = ST_RUN;
                    fld_n = CODE_NONE;
                    isr_n = gie && nmie;
                    res_n = !(gie && nmie);
                end else if (irq_ne && held_mode == MD_PD1_ANY) begin
                    nxt   = ST_RUN;
                    fld_n = CODE_NONE;
                    res_n = 1'b1;
                end
            end
            ST_PD2: begin
                if (!dev_rst_n) begin
                    nxt   = ST_RUN;
                    fld_n = CODE_NONE;
                end
            end
            ST_PD3: begin
                if (!dev_rst_n) begin
                    nxt   = ST_RSTHOLD;
                    fld_n = CODE_NONE;
                end
            end
            ST_RSTHOLD: begin
                if (dev_rst_n) nxt = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (!dev_rst_n)       nxt = ST_RSTHOLD;
                else if (relock_done) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st       <= ST_RUN;
            field    <= CODE_NONE;
            err      <= 1'b0;
            wake_isr <= 1'b0;
            wake_res <= 1'b0;
        end else begin
            st       <= nxt;
            field    <= fld_n;
            err      <= err_n;
            wake_isr <= isr_n;
            wake_res <= res_n;
        end
    end

    // outputs decoded from the state
    always_comb begin
        entry_run   = 1'b0;
        relock_run  = 1'b0;
        mode_active = 1'b0;
        cpu_en      = 1'b1;
        pll_en      = 1'b1;
        unique case (st)
            ST_RUN:   ;
            ST_ENTRY: entry_run = 1'b1;
            ST_PD1: begin
                mode_active = 1'b1;
                cpu_en      = 1'b0;
            end
            ST_PD2, ST_PD3, ST_RSTHOLD: begin
                mode_active = 1'b1;
                cpu_en      = 1'b0;
                pll_en      = 1'b0;
            end
            ST_RELOCK: begin
                relock_run = 1'b1;
                cpu_en     = 1'b0;
                pll_en     = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int ENTRY_CYCLES  = 9,
    parameter int RELOCK_CYCLES = 64
) (
    input  logic                  clk,
    input  logic                  por_n,
    input  logic                  dev_rst_n,
    input  logic                  csr_wr_en,
    input  logic [PD_FIELD_W-1:0] csr_pd_wdata,
    input  logic                  irq_en_pend,
    input  logic                  irq_ne_pend,
    input  logic                  gie,
    input  logic                  nmie,
    output logic [PD_FIELD_W-1:0] pd_field,
    output logic                  mode_active,
    output logic                  cpu_clk_en,
    output logic                  pll_clk_en,
    output logic                  wake_isr,
    output logic                  wake_resume,
    output logic                  code_err
);

    pd_mode_e wr_mode, held_mode;
    logic     entry_run, relock_run, entry_done, relock_done;

    pd_decode u_dec_wr   (.code(csr_pd_wdata), .mode(wr_mode));
    pd_decode u_dec_held (.code(pd_field),     .mode(held_mode));

    pd_timer #(.LIMIT(ENTRY_CYCLES)) u_entry_tmr (
        .clk(clk), .por_n(por_n), .run(entry_run), .done(entry_done)
    );

    pd_timer #(.LIMIT(RELOCK_CYCLES)) u_relock_tmr (
        .clk(clk), .por_n(por_n), .run(relock_run), .done(relock_done)
    );

    pd_fsm u_fsm (
        .clk(clk),
        .por_n(por_n),
        .dev_rst_n(dev_rst_n),
        .wr_en(csr_wr_en),
        .wr_field(csr_pd_wdata),
        .wr_mode(wr_mode),
        .held_mode(held_mode),
        .irq_en(irq_en_pend),
        .irq_ne(irq_ne_pend),
        .gie(gie),
        .nmie(nmie),
        .entry_done(entry_done),
        .relock_done(relock_done),
        .field(pd_field),
        .err(code_err),
        .wake_isr(wake_isr),
        .wake_res(wake_resume),
        .entry_run(entry_run),
        .relock_run(relock_run),
        .mode_active(mode_active),
        .cpu_en(cpu_clk_en),
        .pll_en(pll_clk_en)
    );

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       dev_rst_n,
    input logic       irq_en_pend,
    input logic       irq_ne_pend,
    input logic       gie,
    input logic       nmie,
    input logic [5:0] pd_field,
    input logic       mode_active,
    input logic       cpu_clk_en,
    input logic       pll_clk_en,
    input logic       wake_isr,
    input logic       wake_resume,
    input logic       code_err
);

    p_mode_gates_core_r5: assert property (@(posedge clk) disable iff (!por_n)
        mode_active |-> !cpu_clk_en);

    p_pll_off_core_off_r8: assert property (@(posedge clk) disable iff (!por_n)
        !pll_clk_en |-> !cpu_clk_en);

    p_wake_exclusive_r6: assert property (@(posedge clk) disable iff (!por_n)
        !(wake_isr && wake_resume));

    p_isr_cause_r6: assert property (@(posedge clk) disable iff (!por_n)
        wake_isr |-> $past(irq_en_pend && gie && nmie));

    p_wake_clears_r11: assert property (@(posedge clk) disable iff (!por_n)
        (wake_isr || wake_resume) |-> (pd_field == 6'b000000 && !mode_active && cpu_clk_en));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
        code_err |=> code_err);

    p_field_frozen_r2: assert property (@(posedge clk) disable iff (!por_n)
        (mode_active && dev_rst_n && !irq_en_pend && !irq_ne_pend) |=> $stable(pd_field));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (
    .clk(clk),
    .por_n(por_n),
    .dev_rst_n(dev_rst_n),
    .irq_en_pend(irq_en_pend),
    .irq_ne_pend(irq_ne_pend),
    .gie(gie),
    .nmie(nmie),
    .pd_field(pd_field),
    .mode_active(mode_active),
    .cpu_clk_en(cpu_clk_en),
    .pll_clk_en(pll_clk_en),
    .wake_isr(wake_isr),
    .wake_resume(wake_resume),
    .code_err(code_err)
);

// File: tb/tb_pwrdn_ctrl.sv
module tb_pwrdn_ctrl;

    localparam int ENTRY  = 9;
    localparam int RELOCK = 64;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       dev_rst_n = 1'b1;
    logic       csr_wr_en = 1'b0;
    logic [5:0] csr_pd_wdata = '0;
    logic       irq_en_pend = 1'b0;
    logic       irq_ne_pend = 1'b0;
    logic       gie = 1'b0;
    logic       nmie = 1'b0;
    logic [5:0] pd_field;
    logic       mode_active, cpu_clk_en, pll_clk_en;
    logic       wake_isr, wake_resume, code_err;

    int n_run = 0;
    int n_fail = 0;

    // 125 MHz: 8 ns period
    always #4 clk = ~clk;

    pwrdn_ctrl #(.ENTRY_CYCLES(ENTRY), .RELOCK_CYCLES(RELOCK)) dut (
        .clk(clk), .por_n(por_n), .dev_rst_n(dev_rst_n),
        .csr_wr_en(csr_wr_en), .csr_pd_wdata(csr_pd_wdata),
        .irq_en_pend(irq_en_pend), .irq_ne_pend(irq_ne_pend),
        .gie(gie), .nmie(nmie),
        .pd_field(pd_field), .mode_active(mode_active),
        .cpu_clk_en(cpu_clk_en), .pll_clk_en(pll_clk_en),
        .wake_isr(wake_isr), .wake_resume(wake_resume), .code_err(code_err)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // clocks: {cpu, pll}
    task automatic check_clk(input string req, input int cpu, input int pll);
        check(req, "cpu_clk_en", int'(cpu_clk_en), cpu);
        check(req, "pll_clk_en", int'(pll_clk_en), pll);
    endtask

    task automatic write_field(input logic [5:0] code);
        csr_wr_en    = 1'b1;
        csr_pd_wdata = code;
        tick(1);
        csr_wr_en    = 1'b0;
        csr_pd_wdata = '0;
    endtask

    task automatic enter(input logic [5:0] code);
        write_field(code);
        tick(ENTRY);
    endtask

    task automatic t_reset;
        check("R1", "mode_active", int'(mode_active), 0);
        check_clk("R1", 1, 1);
        check("R1", "pd_field", int'(pd_field), 0);
        check("R1", "code_err", int'(code_err), 0);
        check("R1", "wake", int'(wake_isr) + int'(wake_resume), 0);
    endtask

    task automatic t_pd1_enabled_isr;
        write_field(6'b001001);
        check("R2", "pd_field readback", int'(pd_field), 6'b001001);
        tick(ENTRY - 1);
        check("R4", "mode_active before delay", int'(mode_active), 0);
        check_clk("R4", 1, 1);
        tick(1);
        check("R4", "mode_active at delay", int'(mode_active), 1);
        check_clk("R5", 0, 1);
        // non-enabled interrupt has no effect in enabled-only form
        irq_ne_pend = 1'b1;
        tick(3);
        irq_ne_pend = 1'b0;
        check("R7", "mode_active after ne irq", int'(mode_active), 1);
        check("R7", "wake_resume", int'(wake_resume), 0);
        gie = 1'b1; nmie = 1'b1; irq_en_pend = 1'b1;
        tick(1);
        irq_en_pend = 1'b0;
        check("R6", "wake_isr", int'(wake_isr), 1);
        check("R6", "wake_resume", int'(wake_resume), 0);
        check_clk("R6", 1, 1);
        check("R11", "pd_field cleared", int'(pd_field), 0);
        tick(1);
        check("R6", "wake_isr one cycle", int'(wake_isr), 0);
        gie = 1'b0; nmie = 1'b0;
    endtask

    task automatic t_pd1_enabled_no_isr;
        enter(6'b001001);
        gie = 1'b1; nmie = 1'b0; irq_en_pend = 1'b1; irq_ne_pend = 1'b1;
        tick(1);
        irq_en_pend = 1'b0; irq_ne_pend = 1'b0;
        check("R6", "wake_resume when nmie=0", int'(wake_resume), 1);
        check("R6", "wake_isr when nmie=0", int'(wake_isr), 0);
        gie = 1'b0;
        tick(1);
    endtask

    task automatic t_pd1_any;
        enter(6'b010001);
        check("R3", "PD1 any mode_active", int'(mode_active), 1);
        irq_ne_pend = 1'b1;
        tick(1);
        irq_ne_pend = 1'b0;
        check("R7", "wake_resume on ne irq", int'(wake_resume), 1);
        check("R7", "mode_active", int'(mode_active), 0);
        check("R11", "pd_field cleared", int'(pd_field), 0);
        tick(1);
    endtask

    task automatic t_pd2;
        enter(6'b011010);
        check("R8", "mode_active", int'(mode_active), 1);
        check_clk("R8", 0, 0);
        // write while halted is ignored
        write_field(6'b001001);
        check("R2", "pd_field unchanged", int'(pd_field), 6'b011010);
        irq_en_pend = 1'b1; irq_ne_pend = 1'b1; gie = 1'b1; nmie = 1'b1;
        tick(3);
        irq_en_pend = 1'b0; irq_ne_pend = 1'b0; gie = 1'b0; nmie = 1'b0;
        check("R8", "irq ignored", int'(mode_active), 1);
        check("R8", "no wake pulse", int'(wake_isr) + int'(wake_resume), 0);
        dev_rst_n = 1'b0;
        tick(1);
        check_clk("R8", 1, 1);
        check("R11", "pd_field cleared", int'(pd_field), 0);
        dev_rst_n = 1'b1;
        tick(1);
        check_clk("R8", 1, 1);
    endtask

    task automatic t_pd3;
        enter(6'b011100);
        check("R9", "mode_active", int'(mode_active), 1);
        check_clk("R9", 0, 0);
        irq_en_pend = 1'b1; gie = 1'b1; nmie = 1'b1;
        tick(2);
        irq_en_pend = 1'b0; gie = 1'b0; nmie = 1'b0;
        check("R9", "irq ignored", int'(mode_active), 1);
        dev_rst_n = 1'b0;
        tick(1);
        check("R11", "pd_field cleared", int'(pd_field), 0);
        dev_rst_n = 1'b1;
        tick(1);
        tick(RELOCK - 1);
        check_clk("R9", 0, 0);
        tick(1);
        check_clk("R9", 1, 1);
    endtask

    task automatic t_reserved;
        write_field(6'b100000);
        check("R10", "code_err", int'(code_err), 1);
        tick(ENTRY + 3);
        check("R10", "no entry", int'(mode_active), 0);
        check_clk("R10", 1, 1);
        write_field(6'b011011);
        write_field(6'b000000);
        check("R10", "code_err sticky", int'(code_err), 1);
        por_n = 1'b0;
        tick(1);
        por_n = 1'b1;
        tick(1);
        check("R10", "code_err cleared by por", int'(code_err), 0);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        tick(2);
        por_n = 1'b1;
        tick(1);
        t_reset();
        t_pd1_enabled_isr();
        t_pd1_enabled_no_isr();
        t_pd1_any();
        t_pd2();
        t_pd3();
        t_reserved();
        finish_run();
    end

    initial begin
        #1600000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule